// File: doc/BRIEF.md
# Monte Carlo Pi Estimator

This block estimates pi by streaming random points through a fixed hardware pipeline. Two independent 32-bit xorshift generators provide an x and a y coordinate on every clock. Each coordinate is read as an unsigned fraction in [0,1). The pipeline squares both coordinates, adds the squares, and decides whether the point lies strictly inside the unit quarter-circle. A hit counter and a sample counter collect the results.

Software or a sequencer sets the run length as a power of two, 2^K, and loads the two seeds. It then pulses start. When the last in-flight sample has been counted, the block drops busy and raises done. It then holds three results until the next start: the hit count, the sample count, and the estimate 4·hits/samples in unsigned fixed point with 2 integer bits.

Top module: `mc_pi_estimator`

## Requirements
- R1: After reset, busy_o and done_o are low and hits_o, total_o and estimate_o are zero.
- R2: A start_i pulse while idle raises busy_o on the next clock, lowers done_o, clears both counters and reloads both generators from seed_x_i and seed_y_i. A zero seed is replaced by 32'h9E3779B9.
- R3: Each generator steps as xorshift32: s ^= s<<13, then s ^= s>>17, then s ^= s<<5. Sample n (n = 1, 2, ...) uses the seed stepped n times, on both axes in parallel.
- R4: A sample is a hit exactly when x·x + y·y, formed as a 65-bit sum of two 64-bit squares, is below 2^64.
- R5: A run takes exactly 2^K samples, where K is log2_n_i captured at start. At done, total_o equals 2^K.
- R6: done_o rises in the same cycle that busy_o falls. This happens only once every issued sample has been counted. busy_o and done_o are never high together, and the results hold until the next start.
- R7: estimate_o equals floor(hits·2^(FRAC_W+2) / 2^K) and saturates at 2^(FRAC_W+2)-1.
- R8: A start_i pulse while busy has no effect on the run, its length, its seeds or its results.
- R9: hits_o never exceeds total_o. The hit counter is 64 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| seed_x_i | input | 32 | Seed for the x generator |
| seed_y_i | input | 32 | Seed for the y generator |
| log2_n_i | input | K_W | log2 of the sample count |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Results valid, held until next start |
| hits_o | output | CNT_W | Samples inside the quarter-circle |
| total_o | output | CNT_W | Samples counted |
| estimate_o | output | FRAC_W+2 | Pi estimate, 2 integer bits |

## Verification
The bench uses the default K_W=6, CNT_W=64 and FRAC_W=16. This gives the 18-bit estimate enough fraction bits that a rounding error of even one LSB in the shift changes the output. The test runs use K from 0 to 12. K=0 is the single-sample case, where any hit drives the estimate into saturation. The larger K values run long enough that a start issued mid-run and the drain of a pipeline holding samples fall inside one run.

// File: rtl/mcpi_pkg.sv
package mcpi_pkg;
  localparam int unsigned COORD_W = 32;
  localparam logic [COORD_W-1:0] SEED_SUB = 32'h9E37_79B9;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} ctl_state_e;

  function automatic logic [COORD_W-1:0] xs_step(input logic [COORD_W-1:0] s);
    logic [COORD_W-1:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction
endpackage

// File: rtl/mcpi_xorshift.sv
module mcpi_xorshift
  import mcpi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [COORD_W-1:0] seed_i,
  input  logic               adv_i,
  output logic [COORD_W-1:0] coord_o,
  output logic               valid_o
);
  logic [COORD_W-1:0] state_q, nxt;

  assign nxt = xs_step(state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED_SUB;
      coord_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= adv_i;
      if (load_i) begin
        state_q <= (seed_i == '0) ? SEED_SUB : seed_i;
      end else if (adv_i) begin
        state_q <= nxt;
        coord_o <= nxt;
      end
    end
  end

  // R2
  state_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/mcpi_hit_pipe.sv
module mcpi_hit_pipe
  import mcpi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic               valid_o,
  output logic               hit_o
);
  localparam int unsigned SQ_W = 2 * COORD_W;

  logic [SQ_W-1:0] xx_q, yy_q;
  logic            sq_vld_q;
  logic [SQ_W:0]   sum;

  assign sum = {1'b0, xx_q} + {1'b0, yy_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xx_q     <= '0;
      yy_q     <= '0;
      sq_vld_q <= 1'b0;
      valid_o  <= 1'b0;
      hit_o    <= 1'b0;
    end else begin
      sq_vld_q <= valid_i;
      if (valid_i) begin
        xx_q <= SQ_W'(x_i) * SQ_W'(x_i);
        yy_q <= SQ_W'(y_i) * SQ_W'(y_i);
      end
      valid_o <= sq_vld_q;
      // carry out of the sum means x^2+y^2 >= 1.0
      hit_o   <= sq_vld_q && !sum[SQ_W];
    end
  end

  // R4
  hit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_o);
endmodule

// File: rtl/mcpi_estimate.sv
module mcpi_estimate #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned K_W    = 6,
  parameter int unsigned FRAC_W = 16,
  localparam int unsigned EST_W = FRAC_W + 2,
  localparam int unsigned WIDE_W = CNT_W + EST_W
) (
  input  logic [CNT_W-1:0] hits_i,
  input  logic [K_W-1:0]   k_i,
  output logic [EST_W-1:0] est_o
);
  logic [WIDE_W-1:0] scaled, shifted;

  assign scaled  = {hits_i, {EST_W{1'b0}}};
  assign shifted = scaled >> k_i;

  always_comb begin
    if (shifted[WIDE_W-1:EST_W] != '0) est_o = '1;
    else                               est_o = shifted[EST_W-1:0];
  end
endmodule

// File: rtl/mc_pi_estimator.sv
module mc_pi_estimator
  import mcpi_pkg::*;
#(
  parameter int unsigned K_W    = 6,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned FRAC_W = 16,
  localparam int unsigned EST_W = FRAC_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COORD_W-1:0] seed_x_i,
  input  logic [COORD_W-1:0] seed_y_i,
  input  logic [K_W-1:0]     log2_n_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   hits_o,
  output logic [CNT_W-1:0]   total_o,
  output logic [EST_W-1:0]   estimate_o
);
  ctl_state_e         state_q;
  logic [CNT_W-1:0]   target_q, issue_q, hits_q, tot_q;
  logic [K_W-1:0]     k_q;
  logic               done_q;
  logic               launch, issue, retire, hit, last_retire;
  logic [COORD_W-1:0] seed   [2];
  logic [COORD_W-1:0] coord  [2];
  logic [1:0]         gvalid;

  assign launch      = start_i && (state_q == ST_IDLE);
  assign issue       = (state_q == ST_RUN);
  assign last_retire = retire && (tot_q + 1'b1 == target_q);
  assign seed[0]     = seed_x_i;
  assign seed[1]     = seed_y_i;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    mcpi_xorshift u_gen (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (launch),
      .seed_i  (seed[a]),
      .adv_i   (issue),
      .coord_o (coord[a]),
      .valid_o (gvalid[a])
    );
  end

  mcpi_hit_pipe u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (gvalid[0]),
    .x_i     (coord[0]),
    .y_i     (coord[1]),
    .valid_o (retire),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      issue_q  <= '0;
      hits_q   <= '0;
      tot_q    <= '0;
      k_q      <= '0;
      done_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch) begin
          state_q  <= ST_RUN;
          target_q <= CNT_W'(1) << log2_n_i;
          k_q      <= log2_n_i;
          issue_q  <= '0;
          hits_q   <= '0;
          tot_q    <= '0;
          done_q   <= 1'b0;
        end
        ST_RUN: begin
          issue_q <= issue_q + 1'b1;
          if (issue_q + 1'b1 == target_q) state_q <= ST_DRAIN;
        end
        ST_DRAIN: ;
        default: state_q <= ST_IDLE;
      endcase
      if (retire && state_q != ST_IDLE) begin
        tot_q  <= tot_q + 1'b1;
        hits_q <= hits_q + CNT_W'(hit);
        if (last_retire) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  mcpi_estimate #(.CNT_W(CNT_W), .K_W(K_W), .FRAC_W(FRAC_W)) u_est (
    .hits_i (hits_q),
    .k_i    (k_q),
    .est_o  (estimate_o)
  );

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign hits_o  = hits_q;
  assign total_o = tot_q;

  // R9
  hits_le_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hits_q <= tot_q);
  // R5
  total_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tot_q <= target_q);
  // R6
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R6
  done_full_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (tot_q == target_q) && $fell(busy_o));
  // R8
  start_busy_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> $stable(target_q) && $stable(k_q));
endmodule

// File: tb/mc_pi_estimator_bench.sv
module mc_pi_estimator_bench;
  localparam int unsigned K_W = 6, CNT_W = 64, FRAC_W = 16, EST_W = FRAC_W + 2;
  localparam int unsigned NV = 7;
  // {K, seed_x, seed_y}
  localparam logic [69:0] VEC [NV] = '{
    {6'd4,  32'h0000_0001, 32'h0000_0002},
    {6'd8,  32'hDEAD_BEEF, 32'h1234_5678},
    {6'd10, 32'hCAFE_F00D, 32'h0BAD_5EED},
    {6'd0,  32'h8000_0000, 32'h0000_0003},
    {6'd1,  32'h0000_0000, 32'h0000_0000},
    {6'd12, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
    {6'd5,  32'h0000_0000, 32'h5555_AAAA}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] seed_x = 0, seed_y = 0;
  logic [K_W-1:0] log2_n = 0;
  logic busy, done;
  logic [CNT_W-1:0] hits, total;
  logic [EST_W-1:0] est;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mc_pi_estimator #(.K_W(K_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_mc_pi_estimator (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_x_i(seed_x), .seed_y_i(seed_y),
    .log2_n_i(log2_n), .busy_o(busy), .done_o(done), .hits_o(hits), .total_o(total),
    .estimate_o(est)
  );

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [63:0] model_hits(input int k, input logic [31:0] sx, input logic [31:0] sy);
    logic [31:0] a, b;
    logic [64:0] s;
    logic [63:0] n;
    a = (sx == 0) ? 32'h9E37_79B9 : sx;
    b = (sy == 0) ? 32'h9E37_79B9 : sy;
    n = 0;
    for (int i = 0; i < (1 << k); i++) begin
      a = step(a); b = step(b);
      s = 65'(64'(a) * 64'(a)) + 65'(64'(b) * 64'(b));
      if (s < 65'h1_0000_0000_0000_0000) n++;
    end
    return n;
  endfunction

  function automatic logic [EST_W-1:0] model_est(input logic [63:0] nc, input int k);
    logic [127:0] w;
    w = {64'd0, nc} << (FRAC_W + 2);
    w = w >> k;
    return (w >= (128'd1 << EST_W)) ? {EST_W{1'b1}} : w[EST_W-1:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse_start(input int k, input logic [31:0] sx, input logic [31:0] sy);
    @(negedge clk);
    log2_n = K_W'(k); seed_x = sx; seed_y = sy; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic run_check(input int k, input logic [31:0] sx, input logic [31:0] sy, input string tag);
    logic [63:0] nc;
    nc = model_hits(k, sx, sy);
    wait_done();
    chk({tag, " R6 done"}, 64'(done), 64'd1);
    chk({tag, " R6 busy low"}, 64'(busy), 64'd0);
    chk({tag, " R5 total"}, total, 64'd1 << k);
    chk({tag, " R3 R4 hits"}, hits, nc);
    chk({tag, " R7 estimate"}, 64'(est), 64'(model_est(nc, k)));
    chk({tag, " R9 hits<=total"}, 64'(hits <= total), 64'd1);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 hits", hits, 0);
    chk("R1 total", total, 0);
    chk("R1 estimate", 64'(est), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int k;
      logic [31:0] sx, sy;
      k = int'(VEC[v][69:64]); sx = VEC[v][63:32]; sy = VEC[v][31:0];
      pulse_start(k, sx, sy);
      // R2: one clock after start, busy up, done down, counters cleared
      chk("R2 busy after start", 64'(busy), 1);
      chk("R2 done cleared", 64'(done), 0);
      chk("R2 total cleared", total, 0);
      chk("R2 hits cleared", hits, 0);
      run_check(k, sx, sy, "vec");
      // R6 results held
      repeat (5) @(negedge clk);
      chk("R6 hold total", total, 64'd1 << k);
      chk("R6 hold hits", hits, model_hits(k, sx, sy));
    end

    // R8: start while busy with other K and seeds is ignored
    pulse_start(9, 32'h1357_9BDF, 32'h2468_ACE0);
    repeat (20) @(negedge clk);
    log2_n = 2; seed_x = 32'h1; seed_y = 32'h1; start = 1;
    @(negedge clk);
    start = 0;
    chk("R8 busy kept", 64'(busy), 1);
    run_check(9, 32'h1357_9BDF, 32'h2468_ACE0, "R8");

    // R2 zero seed equals substitute seed
    pulse_start(6, 32'h0, 32'h9E37_79B9);
    wait_done();
    chk("R2 zero seed sub", hits, model_hits(6, 32'h9E37_79B9, 32'h9E37_79B9));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule